// File: doc/BRIEF.md
# Field-Masked Calendar Alarm Comparator

This block watches the packed-decimal time and date fields published by a timekeeping core and compares them with six programmable alarm fields: seconds, minutes, hours, weekday, day of month and month. Each alarm field has its own enable bit, so software can leave any subset of fields out of the comparison. One example is matching only minutes and seconds to get an hourly alarm.

The comparison is taken only on the one-cycle tick that marks a new time value. When every enabled field agrees on that tick, a sticky alarm flag is set. The flag stays set until software clears it. The interrupt output is the flag gated by an interrupt enable, and both bits sit in one control register.

Software reaches the registers through a simple write and read port with registered read data. The alarm fields sit at indices 8 to 13. The control register sits at index 14.

Top module: `alm_match_top`

## Requirements
- R1: After a synchronous reset, all alarm fields, the flag, the interrupt enable and the interrupt output are 0, and read data is 0.
- R2: A write to index 8+k (k: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month) stores the byte. A read returns the stored value one cycle after the read strobe. A read of any index other than 8..14 returns 0.
- R3: Bit 7 of an alarm field enables that field. An enabled field matches when its bits 6:0 equal bits 6:0 of the live field, so bit 7 of the live value is ignored. A disabled field never blocks a match, whatever its value.
- R4: The flag is set one cycle after a tick on which all enabled fields match. A match that is not accompanied by a tick leaves the flag unchanged.
- R5: With no field enabled, the flag is never set, whatever the live time.
- R6: Once set, the flag stays set across later ticks and time changes until software clears it.
- R7: Writing index 14 with bit 0 = 0 clears the flag, and writing bit 0 = 1 never sets it. If a matching tick and a clearing write fall in the same cycle, the flag is set.
- R8: The interrupt output equals the flag AND the interrupt enable (index 14, bit 3) in every cycle after reset.
- R9: A read of index 14 returns the flag in bit 0, the interrupt enable in bit 3, and 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse: the live time fields hold a new value |
| cur_sec | input | 8 | Live seconds, packed decimal |
| cur_min | input | 8 | Live minutes, packed decimal |
| cur_hour | input | 8 | Live hours, packed decimal |
| cur_wday | input | 8 | Live weekday |
| cur_mday | input | 8 | Live day of month, packed decimal |
| cur_mon | input | 8 | Live month 1..12, packed decimal |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The hardest situation to reach is a partial match, where some enabled fields agree and others do not. Several distinct enable subsets have to be tried against several agreement patterns before a wrong reduction, such as an OR in place of an AND or a disabled field that still blocks, becomes visible. The bench sweeps all 64 enable masks against all 64 per-field agreement patterns and clears the flag between points. It also sets the ignored top bit of every live field for half of the masks. A second hard case is a clearing write that lands in the very cycle of a matching tick, and a directed step drives both strobes together on one edge.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int ALM_NF = 6;
  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_MDAY = 3'd4,
    FLD_MON  = 3'd5
  } alm_field_e;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int DW     = 8,
  parameter int EN_BIT = 7
) (
  input  logic [DW-1:0] alarm_reg,
  input  logic [DW-1:0] live_val,
  output logic          fld_en,
  output logic          fld_ok
);
  logic same;

  assign same   = (alarm_reg[EN_BIT-1:0] == live_val[EN_BIT-1:0]);
  assign fld_en = alarm_reg[EN_BIT];
  // a disabled field never blocks the overall match
  assign fld_ok = !fld_en || same;
endmodule

// File: rtl/alm_regs.sv
module alm_regs #(
  parameter int DW       = 8,
  parameter int AW       = 4,
  parameter int NF       = 6,
  parameter int BASE     = 8,
  parameter int CTRL_IDX = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    ctrl_rd,
  output logic [NF*DW-1:0] fld_flat,
  output logic             ctrl_wr,
  output logic [DW-1:0]    rdata
);
  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_IDX);

  logic [DW-1:0] fld_q [NF];

  assign ctrl_wr = wr_en && (addr == CTRL_A);

  for (genvar i = 0; i < NF; i++) begin : g_fld
    localparam logic [AW-1:0] MY_A = AW'(BASE + i);
    always_ff @(posedge clk) begin
      if (rst) fld_q[i] <= '0;
      else if (wr_en && addr == MY_A) fld_q[i] <= wdata;
    end
    assign fld_flat[i*DW +: DW] = fld_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      if (addr == CTRL_A) rdata <= ctrl_rd;
      for (int i = 0; i < NF; i++) begin
        if (addr == AW'(BASE + i)) rdata <= fld_q[i];
      end
    end
  end
endmodule

// File: rtl/alm_flag_ctl.sv
module alm_flag_ctl #(
  parameter int DW       = 8,
  parameter int FLAG_BIT = 0,
  parameter int IE_BIT   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          match,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] wdata,
  output logic          flag_q,
  output logic          aie_q,
  output logic          irq_q,
  output logic [DW-1:0] ctrl_rd
);
  logic flag_d, aie_d;

  always_comb begin
    flag_d = flag_q;
    if (ctrl_wr && !wdata[FLAG_BIT]) flag_d = 1'b0;
    if (tick && match) flag_d = 1'b1;   // set wins over clear
    aie_d = ctrl_wr ? wdata[IE_BIT] : aie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      aie_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      aie_q  <= aie_d;
      irq_q  <= flag_d & aie_d;
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[FLAG_BIT] = flag_q;
    ctrl_rd[IE_BIT]   = aie_q;
  end
endmodule

// File: rtl/alm_match_top.sv
module alm_match_top
  import alm_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 4,
  parameter int EN_BIT   = 7,
  parameter int BASE     = 8,
  parameter int CTRL_IDX = 14,
  parameter int FLAG_BIT = 0,
  parameter int IE_BIT   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic [DW-1:0] cur_wday,
  input  logic [DW-1:0] cur_mday,
  input  logic [DW-1:0] cur_mon,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          alarm_flag,
  output logic          alarm_irq
);
  localparam int NF = ALM_NF;

  logic [DW-1:0]    live [NF];
  logic [NF*DW-1:0] fld_flat;
  logic [NF-1:0]    fld_en, fld_ok;
  logic [DW-1:0]    ctrl_rd;
  logic             ctrl_wr;
  logic             any_en, match;
  logic             alm_aie;

  assign live[FLD_SEC]  = cur_sec;
  assign live[FLD_MIN]  = cur_min;
  assign live[FLD_HOUR] = cur_hour;
  assign live[FLD_WDAY] = cur_wday;
  assign live[FLD_MDAY] = cur_mday;
  assign live[FLD_MON]  = cur_mon;

  alm_regs #(
    .DW(DW), .AW(AW), .NF(NF), .BASE(BASE), .CTRL_IDX(CTRL_IDX)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .ctrl_rd(ctrl_rd),
    .fld_flat(fld_flat), .ctrl_wr(ctrl_wr), .rdata(reg_rdata)
  );

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    alm_field_cmp #(.DW(DW), .EN_BIT(EN_BIT)) u_cmp (
      .alarm_reg(fld_flat[i*DW +: DW]),
      .live_val (live[i]),
      .fld_en   (fld_en[i]),
      .fld_ok   (fld_ok[i])
    );
  end

  assign any_en = |fld_en;
  assign match  = any_en && (&fld_ok);

  alm_flag_ctl #(
    .DW(DW), .FLAG_BIT(FLAG_BIT), .IE_BIT(IE_BIT)
  ) u_flag (
    .clk(clk), .rst(rst), .tick(tick), .match(match),
    .ctrl_wr(ctrl_wr), .wdata(reg_wdata),
    .flag_q(alarm_flag), .aie_q(alm_aie), .irq_q(alarm_irq),
    .ctrl_rd(ctrl_rd)
  );
endmodule

// File: rtl/alm_match_chk.sv
module alm_match_chk #(
  parameter int DW       = 8,
  parameter int AW       = 4,
  parameter int BASE     = 8,
  parameter int NF       = 6,
  parameter int CTRL_IDX = 14,
  parameter int FLAG_BIT = 0
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          alarm_flag,
  input logic          alarm_irq,
  input logic          aie,
  input logic          any_en
);
  logic addr_used, clr_wr;
  assign addr_used = (int'(reg_addr) >= BASE && int'(reg_addr) < BASE + NF) ||
                     (int'(reg_addr) == CTRL_IDX);
  assign clr_wr = reg_wr && (int'(reg_addr) == CTRL_IDX) && !reg_wdata[FLAG_BIT];

  AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd) && !$past(addr_used) |-> reg_rdata == '0); // R2

  AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flag) |-> $past(tick)); // R4

  AST_NO_FIELD_NO_SET: assert property (@(posedge clk) disable iff (rst)
    !alarm_flag && !any_en |=> !alarm_flag); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    alarm_flag && !clr_wr |=> alarm_flag); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    alarm_irq == (alarm_flag && aie)); // R8
endmodule

bind alm_match_top alm_match_chk #(
  .DW(DW), .AW(AW), .BASE(BASE), .NF(alm_pkg::ALM_NF),
  .CTRL_IDX(CTRL_IDX), .FLAG_BIT(FLAG_BIT)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .alarm_flag(alarm_flag), .alarm_irq(alarm_irq), .aie(alm_aie),
  .any_en(any_en)
);

// File: tb/alm_match_top_bench.sv
module alm_match_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] cur [6];
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       alarm_flag, alarm_irq;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0] aval [6] = '{8'h45, 8'h30, 8'h12, 8'h03, 8'h28, 8'h11};

  always #10 clk = ~clk;

  alm_match_top u_alm_match_top (
    .clk(clk), .rst(rst), .tick(tick),
    .cur_sec(cur[0]), .cur_min(cur[1]), .cur_hour(cur[2]),
    .cur_wday(cur[3]), .cur_mday(cur[4]), .cur_mon(cur[5]),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_live_match();
    for (int i = 0; i < 6; i++) cur[i] = aval[i];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) cur[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(alarm_flag == 1'b0, "R1 flag", alarm_flag, 0);
    chk(alarm_irq == 1'b0, "R1 irq", alarm_irq, 0);
    chk(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
    for (int i = 0; i < 6; i++) rd_chk(4'(8 + i), 8'h00, "R1 field");
    rd_chk(4'd14, 8'h00, "R1 ctrl");

    // R2 readback and unused indices
    for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'(8'h5A + i));
    for (int i = 0; i < 6; i++) rd_chk(4'(8 + i), 8'(8'h5A + i), "R2 readback");
    for (int a = 0; a < 16; a++)
      if (a < 8 || a == 15) rd_chk(4'(a), 8'h00, "R2 unused index");

    // R5 no field enabled: live equals stored low bits, still no set
    for (int i = 0; i < 6; i++) begin
      wr(4'(8 + i), aval[i]);
      cur[i] = aval[i];
    end
    pulse_tick();
    chk(alarm_flag == 1'b0, "R5 no enable", alarm_flag, 0);

    // R3/R5 sweep: enable mask m versus agreement pattern p
    for (int m = 0; m < 64; m++) begin
      for (int i = 0; i < 6; i++) wr(4'(8 + i), (m[i] ? 8'h80 : 8'h00) | aval[i]);
      for (int p = 0; p < 64; p++) begin
        bit exp;
        for (int i = 0; i < 6; i++)
          cur[i] = (p[i] ? aval[i] : (aval[i] ^ 8'h01)) | (m[0] ? 8'h80 : 8'h00);
        exp = (m != 0) && ((m & ~p & 63) == 0);
        pulse_tick();
        chk(alarm_flag == exp, (m == 0) ? "R5 sweep" : "R3 sweep", alarm_flag, exp);
        if (alarm_flag) wr(4'd14, 8'h00);
      end
    end

    // R4 match without tick does nothing; with tick sets
    for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'h80 | aval[i]);
    set_live_match();
    repeat (5) @(negedge clk);
    chk(alarm_flag == 1'b0, "R4 no tick", alarm_flag, 0);
    pulse_tick();
    chk(alarm_flag == 1'b1, "R4 tick sets", alarm_flag, 1);

    // R6 sticky across non-matching ticks
    cur[0] = 8'h46;
    pulse_tick();
    pulse_tick();
    chk(alarm_flag == 1'b1, "R6 sticky", alarm_flag, 1);

    // R8 / R9 enable gating and control readback
    chk(alarm_irq == 1'b0, "R8 irq off", alarm_irq, 0);
    wr(4'd14, 8'h09);
    chk(alarm_irq == 1'b1, "R8 irq on", alarm_irq, 1);
    rd_chk(4'd14, 8'h09, "R9 ctrl both");
    wr(4'd14, 8'h01);
    chk(alarm_irq == 1'b0, "R8 irq masked", alarm_irq, 0);
    rd_chk(4'd14, 8'h01, "R9 ctrl flag only");

    // R7 clear, then write of 1 does not set
    wr(4'd14, 8'h08);
    chk(alarm_flag == 1'b0, "R7 clear", alarm_flag, 0);
    rd_chk(4'd14, 8'h08, "R9 ctrl enable only");
    wr(4'd14, 8'h09);
    chk(alarm_flag == 1'b0, "R7 write one", alarm_flag, 0);
    chk(alarm_irq == 1'b0, "R8 irq no flag", alarm_irq, 0);

    // R7 matching tick with clear in the same cycle: set wins
    set_live_match();
    @(negedge clk);
    tick = 1'b1; reg_wr = 1'b1; reg_addr = 4'd14; reg_wdata = 8'h08;
    @(negedge clk);
    tick = 1'b0; reg_wr = 1'b0;
    chk(alarm_flag == 1'b1, "R7 set wins", alarm_flag, 1);
    chk(alarm_irq == 1'b1, "R8 irq with set", alarm_irq, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule